// File: doc/BRIEF.md
# Channel-Aware Audio Sample FIFO

This block sits between a register-style write port and an audio serializer and buffers interleaved multi-channel samples. Software (or a data mover) pushes 24-bit samples one word at a time. The serializer pops them in the same order. The storage is a single RAM of `256 << SIZE_CODE` words. The usable depth depends on the configured channel count. The frames held per channel equal the capacity halved once for each doubling needed to reach the channel count. As a result, three channels are stored in four-channel units, and five to seven channels in eight-channel units. The word limit is that frame depth times the channel count, so the read and write pointers wrap at the limit rather than at the RAM size.

A status word reports how many whole frames are stored. It also holds two sticky error flags: one for a push that found the FIFO full and one for a pop that found it empty. A control write can empty the FIFO in a single cycle. The same write can arm an interrupt request that is raised whenever the FIFO is at most half full. The channel count is changed only while the FIFO is empty, normally in the cycle after a clear.

Top module: `audio_chan_fifo`

## Requirements
- R1: After reset, `status_o` is zero, `irq_o` is low and `pop_data_o` is zero.
- R2: The FIFO accepts at most L words.
  - With n = `cfg_chan_i`+1 and s the smallest integer with 2^s >= n, L = ((256 << SIZE_CODE) >> s) * n.
  - A push while L words are stored and no pop succeeds in the same cycle is dropped, and it sets the overrun flag at `status_o` bit 4.
- R3: `status_o` bits 16:8 hold floor(words / n), saturated at 511. All other status bits except 4 and 0 read zero.
- R4: Popped words come out in push order. Only bits 23:0 of `push_data_i` are stored. `pop_data_o` shows the popped word from the cycle after the pop and holds it until the next pop.
- R5: A pop from an empty FIFO sets `pop_data_o` to zero and sets the underrun flag at `status_o` bit 0.
- R6: Both error flags are sticky. A status write clears each flag whose written bit (4 or 0) is zero and leaves it unchanged otherwise. A new error event in the same cycle as the write wins.
- R7: A control write with bit 0 set empties the FIFO by the next cycle, and a push or pop in that cycle is ignored. Bit 0 is not retained, and the error flags are unaffected.
- R8: Control bit 20 (latched on every control write) enables the request. `irq_o` is high exactly when it is set and the stored word count is at most floor(L/2).
- R9: With L words stored, a push and a pop in the same cycle both take effect. The count stays at L and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_chan_i | input | CHAN_W | Channel count minus one |
| push_i | input | 1 | Push one word |
| push_data_i | input | 32 | Write data, low 24 bits stored |
| pop_i | input | 1 | Pop one word toward the serializer |
| pop_data_o | output | DATA_W | Last popped word |
| ctrl_we_i | input | 1 | Control write strobe |
| ctrl_wdata_i | input | 32 | Control data: bit 0 clear, bit 20 half-level request enable |
| stat_we_i | input | 1 | Status write strobe |
| stat_wdata_i | input | 32 | Status write data: bits 4 and 0 keep-masks for the flags |
| status_o | output | 32 | Frame count and error flags |
| irq_o | output | 1 | Half-level request |

## Verification
The bench builds the block with SIZE_CODE = 0, a 256-word RAM. Every channel count therefore reaches full within a few hundred pushes, and with one channel the 9-bit frame field reaches its top count of 256. It sweeps the channel counts 1, 2, 3, 4, 5, 7 and 8. The counts 3, 5 and 7 bring pointer wrap at the non-power-of-two limits 192, 160 and 224 within reach, and they leave partial frames in the frame field. Random push-heavy and pop-heavy phases drive the FIFO into overrun and underrun. Directed steps cover a clear during a push, a simultaneous push and pop when full, and masked status writes.

// File: rtl/audio_fifo_pkg.sv
package audio_fifo_pkg;

    localparam int CTRL_CLR_BIT  = 0;
    localparam int CTRL_HALF_BIT = 20;
    localparam int ST_UNDER_BIT  = 0;
    localparam int ST_OVER_BIT   = 4;
    localparam int ST_FRM_LSB    = 8;
    localparam int ST_FRM_W      = 9;
    localparam int ST_FRM_MAX    = (1 << ST_FRM_W) - 1;

    // number of halvings needed so that 2**result >= n
    function automatic int chan_shift(input int n);
        int sh;
        sh = 0;
        for (int i = 0; i < 8; i++) begin
            if ((1 << sh) < n) sh++;
        end
        return sh;
    endfunction

endpackage

// File: rtl/audio_fifo_geom.sv
module audio_fifo_geom #(
    parameter int CAP    = 256,
    parameter int CHAN_W = 3,
    parameter int CW     = 9
) (
    input  logic [CHAN_W-1:0] chan_code_i,
    output logic [CHAN_W:0]   nchan_o,
    output logic [CW-1:0]     limit_o,
    output logic [CW-1:0]     half_o
);
    import audio_fifo_pkg::*;

    int sh;
    int per_chan;

    always_comb begin
        nchan_o  = {1'b0, chan_code_i} + {{CHAN_W{1'b0}}, 1'b1};
        sh       = chan_shift(int'(nchan_o));
        per_chan = CAP >> sh;
        limit_o  = CW'(per_chan * int'(nchan_o));
        half_o   = limit_o >> 1;
    end

endmodule

// File: rtl/audio_fifo_level.sv
module audio_fifo_level #(
    parameter int CW     = 9,
    parameter int CHAN_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              push_req_i,
    input  logic              pop_req_i,
    input  logic [CHAN_W:0]   nchan_i,
    input  logic [CW-1:0]     limit_i,
    output logic              do_push_o,
    output logic              do_pop_o,
    output logic              empty_o,
    output logic              over_evt_o,
    output logic              under_evt_o,
    output logic [CW-1:0]     words_o,
    output logic [CW-1:0]     frames_o
);
    typedef struct packed {
        logic [CW-1:0]   words;
        logic [CW-1:0]   frames;
        logic [CHAN_W:0] rem;
    } lvl_t;

    lvl_t lvl_d, lvl_q;
    logic full;

    always_comb begin
        lvl_d       = lvl_q;
        empty_o     = (lvl_q.words == '0);
        full        = (lvl_q.words == limit_i);
        do_pop_o    = 1'b0;
        do_push_o   = 1'b0;
        over_evt_o  = 1'b0;
        under_evt_o = 1'b0;
        if (clr_i) begin
            lvl_d = '0;
        end else begin
            do_pop_o    = pop_req_i && !empty_o;
            do_push_o   = push_req_i && (!full || do_pop_o);
            over_evt_o  = push_req_i && !do_push_o;
            under_evt_o = pop_req_i && empty_o;
            if (do_push_o && !do_pop_o) begin
                lvl_d.words = lvl_q.words + 1'b1;
                if (lvl_q.rem + 1'b1 == nchan_i) begin
                    lvl_d.frames = lvl_q.frames + 1'b1;
                    lvl_d.rem    = '0;
                end else begin
                    lvl_d.rem = lvl_q.rem + 1'b1;
                end
            end else if (do_pop_o && !do_push_o) begin
                lvl_d.words = lvl_q.words - 1'b1;
                if (lvl_q.rem == '0) begin
                    lvl_d.frames = lvl_q.frames - 1'b1;
                    lvl_d.rem    = nchan_i - 1'b1;
                end else begin
                    lvl_d.rem = lvl_q.rem - 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= '0;
        else        lvl_q <= lvl_d;
    end

    assign words_o  = lvl_q.words;
    assign frames_o = lvl_q.frames;

    p_no_overflow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_q.words <= limit_i)
        else $error("word count above limit");

    p_rem_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_q.rem < nchan_i)
        else $error("partial frame remainder out of range");

    p_both_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (do_push_o && do_pop_o) |=> $stable(lvl_q.words))
        else $error("simultaneous push and pop changed the count");

endmodule

// File: rtl/audio_fifo_store.sv
module audio_fifo_store #(
    parameter int DATA_W = 24,
    parameter int CAP    = 256,
    parameter int AW     = 8,
    parameter int CW     = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              do_push_i,
    input  logic              do_pop_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [CW-1:0]     limit_i,
    output logic [DATA_W-1:0] rdata_o
);
    typedef struct packed {
        logic [AW-1:0] wp;
        logic [AW-1:0] rp;
    } ptr_t;

    ptr_t ptr_d, ptr_q;
    logic [DATA_W-1:0] mem [CAP];

    function automatic logic [AW-1:0] step(input logic [AW-1:0] p,
                                           input logic [CW-1:0] lim);
        if ({1'b0, p} == lim - 1'b1) return '0;
        return p + 1'b1;
    endfunction

    always_comb begin
        ptr_d = ptr_q;
        if (clr_i) begin
            ptr_d = '0;
        end else begin
            if (do_push_i) ptr_d.wp = step(ptr_q.wp, limit_i);
            if (do_pop_i)  ptr_d.rp = step(ptr_q.rp, limit_i);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    always_ff @(posedge clk) begin
        if (do_push_i) mem[ptr_q.wp] <= wdata_i;
    end

    assign rdata_o = mem[ptr_q.rp];

    p_ptr_range_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, ptr_q.wp} < limit_i) && ({1'b0, ptr_q.rp} < limit_i))
        else $error("pointer beyond word limit");

endmodule

// File: rtl/audio_chan_fifo.sv
module audio_chan_fifo #(
    parameter int SIZE_CODE = 0,
    parameter int DATA_W    = 24,
    parameter int CHAN_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CHAN_W-1:0] cfg_chan_i,
    input  logic              push_i,
    input  logic [31:0]       push_data_i,
    input  logic              pop_i,
    output logic [DATA_W-1:0] pop_data_o,
    input  logic              ctrl_we_i,
    input  logic [31:0]       ctrl_wdata_i,
    input  logic              stat_we_i,
    input  logic [31:0]       stat_wdata_i,
    output logic [31:0]       status_o,
    output logic              irq_o
);
    import audio_fifo_pkg::*;

    localparam int CAP = 256 << SIZE_CODE;
    localparam int AW  = $clog2(CAP);
    localparam int CW  = AW + 1;

    typedef struct packed {
        logic              half_en;
        logic              over;
        logic              under;
        logic [DATA_W-1:0] pop_data;
    } top_t;

    top_t st_d, st_q;

    logic              clr;
    logic [CHAN_W:0]   nchan;
    logic [CW-1:0]     limit, half;
    logic              do_push, do_pop, empty, over_evt, under_evt;
    logic [CW-1:0]     words, frames;
    logic [DATA_W-1:0] rdata;
    logic [ST_FRM_W-1:0] frm_field;
    logic              unused_bits;

    assign clr = ctrl_we_i && ctrl_wdata_i[CTRL_CLR_BIT];
    assign unused_bits = ^{push_data_i[31:DATA_W], ctrl_wdata_i, stat_wdata_i};

    audio_fifo_geom #(.CAP(CAP), .CHAN_W(CHAN_W), .CW(CW)) u_geom (
        .chan_code_i (cfg_chan_i),
        .nchan_o     (nchan),
        .limit_o     (limit),
        .half_o      (half)
    );

    audio_fifo_level #(.CW(CW), .CHAN_W(CHAN_W)) u_level (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr),
        .push_req_i  (push_i),
        .pop_req_i   (pop_i),
        .nchan_i     (nchan),
        .limit_i     (limit),
        .do_push_o   (do_push),
        .do_pop_o    (do_pop),
        .empty_o     (empty),
        .over_evt_o  (over_evt),
        .under_evt_o (under_evt),
        .words_o     (words),
        .frames_o    (frames)
    );

    audio_fifo_store #(.DATA_W(DATA_W), .CAP(CAP), .AW(AW), .CW(CW)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (clr),
        .do_push_i (do_push),
        .do_pop_i  (do_pop),
        .wdata_i   (push_data_i[DATA_W-1:0]),
        .limit_i   (limit),
        .rdata_o   (rdata)
    );

    always_comb begin
        st_d = st_q;
        if (ctrl_we_i) st_d.half_en = ctrl_wdata_i[CTRL_HALF_BIT];
        if (!clr && pop_i) st_d.pop_data = empty ? '0 : rdata;
        if (stat_we_i) begin
            st_d.over  = st_q.over  & stat_wdata_i[ST_OVER_BIT];
            st_d.under = st_q.under & stat_wdata_i[ST_UNDER_BIT];
        end
        if (over_evt)  st_d.over  = 1'b1;
        if (under_evt) st_d.under = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (32'(frames) > ST_FRM_MAX) frm_field = ST_FRM_W'(ST_FRM_MAX);
        else                          frm_field = ST_FRM_W'(frames);
        status_o = '0;
        status_o[ST_FRM_LSB +: ST_FRM_W] = frm_field;
        status_o[ST_OVER_BIT]  = st_q.over;
        status_o[ST_UNDER_BIT] = st_q.under;
    end

    assign pop_data_o = st_q.pop_data;
    assign irq_o      = st_q.half_en && (words <= half);

    p_full_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !clr && words == limit) |=> st_q.over)
        else $error("dropped push did not flag overrun");

    p_under_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !clr && words == '0) |=> (st_q.pop_data == '0 && st_q.under))
        else $error("empty pop not zero or not flagged");

    p_under_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.under && !stat_we_i) |=> st_q.under)
        else $error("underrun flag dropped without a status write");

    p_over_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.over && !stat_we_i) |=> st_q.over)
        else $error("overrun flag dropped without a status write");

    p_clear_empty_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (words == '0 && frames == '0))
        else $error("clear did not empty the FIFO");

    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.half_en |-> !irq_o)
        else $error("request raised while disabled");

endmodule

// File: tb/audio_chan_fifo_bench.sv
module audio_chan_fifo_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  cfg_chan = 3'd0;
    logic        push = 1'b0, pop = 1'b0, ctrl_we = 1'b0, stat_we = 1'b0;
    logic [31:0] push_data = '0, ctrl_wdata = '0, stat_wdata = '0;
    logic [23:0] pop_data;
    logic [31:0] status;
    logic        irq;

    int checks = 0;
    int errors = 0;

    logic [23:0] q[$];
    bit          m_over, m_under, m_half;
    logic [23:0] m_pop;
    int          m_n = 1;

    always #5 clk = ~clk;

    audio_chan_fifo #(.SIZE_CODE(0), .DATA_W(24), .CHAN_W(3)) u_audio_chan_fifo (
        .clk          (clk),
        .rst_n        (rst_n),
        .cfg_chan_i   (cfg_chan),
        .push_i       (push),
        .push_data_i  (push_data),
        .pop_i        (pop),
        .pop_data_o   (pop_data),
        .ctrl_we_i    (ctrl_we),
        .ctrl_wdata_i (ctrl_wdata),
        .stat_we_i    (stat_we),
        .stat_wdata_i (stat_wdata),
        .status_o     (status),
        .irq_o        (irq)
    );

    function automatic int lim_of(input int n);
        int sh = 0;
        while ((1 << sh) < n) sh++;
        return (256 >> sh) * n;
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic compare_all();
        int frm = q.size() / m_n;
        if (frm > 511) frm = 511;
        chk(status[16:8] == frm, "R3 frame field", status[16:8], frm);
        chk(status[4] == m_over, "R2 overrun flag", status[4], m_over);
        chk(status[0] == m_under, "R5 underrun flag", status[0], m_under);
        chk({status[31:17], status[7:5], status[3:1]} == '0, "R3 reserved bits", status, 0);
        chk(irq == (m_half && q.size() <= lim_of(m_n) / 2), "R8 request", irq,
            (m_half && q.size() <= lim_of(m_n) / 2));
        chk(pop_data == m_pop, "R4 pop data", pop_data, m_pop);
    endtask

    task automatic cyc(input bit ps, input logic [31:0] pd, input bit pp,
                       input bit cw, input logic [31:0] cwd,
                       input bit sw, input logic [31:0] swd);
        bit clr, empty, full, dpop, dpush, oe, ue;
        push = ps; push_data = pd; pop = pp;
        ctrl_we = cw; ctrl_wdata = cwd; stat_we = sw; stat_wdata = swd;
        @(posedge clk);
        #1;
        push = 1'b0; pop = 1'b0; ctrl_we = 1'b0; stat_we = 1'b0;
        clr = cw && cwd[0];
        oe = 1'b0; ue = 1'b0;
        if (cw) m_half = cwd[20];
        if (clr) begin
            q.delete();
        end else begin
            empty = (q.size() == 0);
            full  = (q.size() == lim_of(m_n));
            dpop  = pp && !empty;
            dpush = ps && (!full || dpop);
            if (pp) begin
                if (empty) begin m_pop = '0; ue = 1'b1; end
                else m_pop = q[0];
            end
            if (ps && !dpush) oe = 1'b1;
            if (dpop) void'(q.pop_front());
            if (dpush) q.push_back(pd[23:0]);
        end
        if (sw) begin
            m_over  = m_over  & swd[4];
            m_under = m_under & swd[0];
        end
        m_over  = m_over  | oe;
        m_under = m_under | ue;
        compare_all();
    endtask

    task automatic idle();
        cyc(0, '0, 0, 0, '0, 0, '0);
    endtask

    task automatic set_chan(input int n, input bit half_en);
        cyc(0, '0, 0, 1, (32'(half_en) << 20) | 32'h1, 0, '0);
        cfg_chan = 3'(n - 1);
        m_n = n;
        idle();
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int chans[7] = '{1, 2, 3, 4, 5, 7, 8};
        void'($urandom(32'h5eed_a0d1));
        m_pop = '0;
        #12;
        // R1 reset state
        chk(status == 32'h0, "R1 status after reset", status, 0);
        chk(irq == 1'b0, "R1 irq after reset", irq, 0);
        chk(pop_data == '0, "R1 pop data after reset", pop_data, 0);
        rst_n = 1'b1;
        idle();

        foreach (chans[ci]) begin
            set_chan(chans[ci], ci[0]);
            for (int i = 0; i < 450; i++) begin
                bit sw = ($urandom_range(0, 99) < 3);
                cyc($urandom_range(0, 99) < 85, $urandom, $urandom_range(0, 99) < 12,
                    0, '0, sw, $urandom);
            end
            for (int i = 0; i < 450; i++) begin
                bit sw = ($urandom_range(0, 99) < 3);
                cyc($urandom_range(0, 99) < 12, $urandom, $urandom_range(0, 99) < 85,
                    0, '0, sw, $urandom);
            end
        end

        // R9: full FIFO with one channel, push and pop together
        set_chan(1, 1'b1);
        cyc(0, '0, 0, 0, '0, 1, 32'h0);
        for (int i = 0; i < 256; i++) cyc(1, 32'hAB00_0000 | i, 0, 0, '0, 0, '0);
        chk(status[16:8] == 256, "R3 one channel full field", status[16:8], 256);
        cyc(1, 32'h0012_3456, 1, 0, '0, 0, '0);
        chk(status[4] == 1'b0, "R9 no overrun on push with pop", status[4], 0);
        chk(status[16:8] == 256, "R9 count stays at limit", status[16:8], 256);
        chk(pop_data == 24'h000000, "R9 first word popped", pop_data, 0);
        // R2: extra push on full is dropped
        cyc(1, 32'h00FF_FFFF, 0, 0, '0, 0, '0);
        chk(status[4] == 1'b1, "R2 overrun on full push", status[4], 1);
        // R6: masked status writes
        cyc(0, '0, 0, 0, '0, 1, 32'h0000_0010);
        chk(status[4] == 1'b1, "R6 flag kept when written one", status[4], 1);
        cyc(0, '0, 0, 0, '0, 1, 32'h0);
        chk(status[4] == 1'b0, "R6 flag cleared by zero write", status[4], 0);

        // R7: clear with a push in the same cycle, three channels
        set_chan(3, 1'b0);
        for (int i = 0; i < 10; i++) cyc(1, $urandom, 0, 0, '0, 0, '0);
        cyc(0, '0, 1, 0, '0, 0, '0);
        cyc(0, '0, 1, 0, '0, 0, '0);
        cyc(1, 32'h0077_7777, 0, 1, 32'h0010_0001, 0, '0);
        chk(status[16:8] == 0, "R7 cleared frame field", status[16:8], 0);
        cyc(0, '0, 1, 0, '0, 0, '0);
        chk(status[0] == 1'b1 && pop_data == '0, "R7 pop after clear underruns",
            {status[0], pop_data}, 25'h1_000000);
        cyc(1, 32'h0011_1111, 0, 0, '0, 0, '0);
        cyc(1, 32'h0022_2222, 0, 0, '0, 0, '0);
        cyc(1, 32'h0033_3333, 0, 0, '0, 0, '0);
        chk(status[16:8] == 1, "R7 clear bit not retained", status[16:8], 1);
        cyc(0, '0, 1, 0, '0, 0, '0);
        chk(pop_data == 24'h111111, "R4 order after clear", pop_data, 24'h111111);

        summary();
        $finish;
    end

endmodule